// File: doc/BRIEF.md
# Shared Open-Drain Interrupt Line Controller

This block lets software drive and observe four active-low interrupt lines that are shared with other devices on a board. Each line is an open-drain wire with an external pull-up. The block only ever pulls a line low, by raising an output enable. It never drives a line high. Software works through one control word that holds three fields: a request bit per line, a driver enable bit per line, and a read-only sense bit per line.

A line is pulled low only when both its request bit and its enable bit are set. The sense field reports the real level seen on each pin, inverted so that 1 means asserted. It therefore also shows an assertion made by any other device that shares the line. Each pin level passes through a two-flop synchroniser before it reaches the sense field.

Top module: `irq_line_ctrl`

## Requirements
- R1: Control word bits 3:0 are the request bits for lines A..D (bit 0 = A). A write stores them, and they read back from the following cycle.
- R2: Control word bits 7:4 are the driver enables for lines A..D (bit 4 = A). A write stores them, and they read back from the following cycle. With no write, bits 7:0 hold their value.
- R3: `pin_oe[i]` is 1, meaning line i is pulled low, exactly when request bit i and enable bit i are both 1. Otherwise the line is released.
- R4: Control word bits 11:8 report line A..D (bit 8 = A) as 1 when the pin is low and as 0 when it is high. This holds whether the line is pulled low by this block or by another device.
- R5: Bits 11:8 cannot be written, and writes to bits 31:12 are ignored. Bits 31:12 always read 0.
- R6: A change on `pin_in` shows in the sense field after exactly two rising clock edges, and not after one.
- R7: While `rst_n` is low, and after reset, the request and enable fields are 0 and every `pin_oe` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Control word: request, enable and sense fields |
| pin_oe | output | 4 | Per-line pull-low enable (1 = drive pin low) |
| pin_in | input | 4 | Per-line pin level (1 = high) |

## Verification
The bench models each line as a pull-up wired-AND of `pin_oe` and an external pull-down. It then looks at the cases where a request bit is set without its enable, or an enable without its request. A design that used OR, or that ignored one of the two bits, would pull the line low there. The bench asserts lines from outside while the drivers are off; a sense field taken from the internal request rather than from the pin would read 0. It writes ones to the sense bits and the upper bits; a design that stored them would read them back. It samples the sense field one edge and then two edges after a pin change; a design with a missing or extra synchroniser stage would show the new value at the wrong edge.

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl #(
  parameter int LINES  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic [LINES-1:0]  pin_oe,
  input  logic [LINES-1:0]  pin_in
);
  localparam int USED_W = 3 * LINES;

  logic [LINES-1:0] req_q, ena_q, sync1_q, sync2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      ena_q <= '0;
    end else if (wr_en) begin
      req_q <= wr_data[LINES-1:0];
      ena_q <= wr_data[2*LINES-1:LINES];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '1;
      sync2_q <= '1;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  assign pin_oe  = req_q & ena_q;
  assign rd_data = {{(WORD_W-USED_W){1'b0}}, ~sync2_q, ena_q, req_q};
endmodule

// File: rtl/irq_line_ctrl_chk.sv
module irq_line_ctrl_chk #(
  parameter int LINES  = 4,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W-1:0] rd_data,
  input logic [LINES-1:0]  pin_oe,
  input logic [LINES-1:0]  pin_in
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_write_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 0 && $past(wr_en)) |-> rd_data[LINES-1:0] == $past(wr_data[LINES-1:0]));

  assert_hold_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 0 && !$past(wr_en)) |-> $stable(rd_data[2*LINES-1:0]));

  assert_oe_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe == (rd_data[LINES-1:0] & rd_data[2*LINES-1:LINES]));

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[WORD_W-1:3*LINES] == '0);

  assert_sense_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2) |-> rd_data[3*LINES-1:2*LINES] == ~$past(pin_in, 2));

  always_comb begin
    if (!rst_n) assert_reset_release_R7: assert (pin_oe == '0);
  end
endmodule

bind irq_line_ctrl irq_line_ctrl_chk #(.LINES(LINES), .WORD_W(WORD_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pin_oe(pin_oe), .pin_in(pin_in)
);

// File: tb/test_irq_line_ctrl.sv
module test_irq_line_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  pin_oe;
  logic [3:0]  ext_pull = '0;
  logic [3:0]  pin_in;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  assign pin_in = ~(pin_oe | ext_pull);

  always #10 clk = ~clk;

  irq_line_ctrl i_irq_line_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_oe(pin_oe), .pin_in(pin_in)
  );

  function automatic logic [3:0] exp_oe(logic [31:0] w);
    return w[3:0] & w[7:4];
  endfunction

  function automatic logic [31:0] exp_word(logic [31:0] w, logic [3:0] ext);
    return {20'b0, exp_oe(w) | ext, w[7:4], w[3:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_word(logic [31:0] w);
    @(negedge clk);
    wr_data = w;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = $urandom;
  endtask

  task automatic settle_and_check(logic [31:0] w);
    repeat (3) @(negedge clk);
    check("R1/R2/R4/R5 word", rd_data, exp_word(w, ext_pull));
    check("R3 pin_oe", {28'b0, pin_oe}, {28'b0, exp_oe(w)});
  endtask

  initial begin
    logic [31:0] w;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R7 oe in reset", {28'b0, pin_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 word after reset", rd_data, 32'h0);
    check("R7 oe after reset", {28'b0, pin_oe}, 32'h0);

    w = 32'hFFFF_FFFF;
    write_word(w);
    check("R1/R2 readback next cycle", {24'b0, rd_data[7:0]}, 32'hFF);
    settle_and_check(w);

    w = 32'h0000_000F;
    write_word(w);
    settle_and_check(w);
    w = 32'h0000_00F0;
    write_word(w);
    settle_and_check(w);
    w = 32'h0000_0F3C;
    write_word(w);
    settle_and_check(w);

    w = 32'h0;
    write_word(w);
    repeat (3) @(negedge clk);
    ext_pull = 4'b0101;
    @(negedge clk);
    check("R6 one edge no change", {28'b0, rd_data[11:8]}, 32'h0);
    @(negedge clk);
    check("R6 two edges updated", {28'b0, rd_data[11:8]}, 32'h5);
    check("R4 external assert", rd_data, exp_word(w, ext_pull));
    ext_pull = 4'b0;
    @(negedge clk);
    check("R6 release one edge", {28'b0, rd_data[11:8]}, 32'h5);
    @(negedge clk);
    check("R6 release two edges", {28'b0, rd_data[11:8]}, 32'h0);

    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 hold without write", {24'b0, rd_data[7:0]}, 32'h0);

    for (int i = 0; i < 60; i++) begin
      w = $urandom;
      ext_pull = 4'($urandom);
      write_word(w);
      settle_and_check(w);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule